// File: doc/BRIEF.md
# Register Map Tables with Committed Checkpoint

This block tracks where the newest value of every architectural register lives in a merged physical register file. A speculative table, indexed by architectural register, holds a physical register number and a pending flag for each entry. The front end looks up source operands through several read ports, and each lookup returns a physical index and a ready flag. A destination rename installs a freshly allocated physical register and hands back the mapping it replaced, so that the caller can free that register once the renaming instruction retires.

When a producing write completes, the writeback port clears the pending flag. The clear happens only if the entry still points at the completing physical register, so a younger rename of the same register is not disturbed. A second table holds only retired mappings, and the commit port updates one of its entries. Commit moves pointers only and copies no register values. When a mispredict or an interrupt raises `rollback`, the speculative table is overwritten by the retired table in one cycle, and every pending flag is cleared.

Rename requests use a valid/ready handshake. A rename takes effect only in a cycle where both `ren_valid` and `ren_ready` are high. `ren_ready` is low during a rollback cycle, and the producer must then hold its request. Writeback, commit and rollback are plain control inputs with no back-pressure.

Top module: `reg_map_unit`

## Requirements
- R1: After reset, both tables map architectural register i to physical register i, and no entry is pending, so every lookup of register i returns phys i with ready 1.
- R2: Each source port combinationally returns the physical number mapped to its architectural index. `src_ready` is 1 when that entry is not pending and 0 when it is pending.
- R3: An accepted rename writes `ren_phys` into entry `ren_arch` and sets its pending flag. Lookups see the change from the next cycle on.
- R4: `ren_old_phys` combinationally shows the mapping that entry `ren_arch` holds before the clock edge, which is the register to free later.
- R5: A source lookup of an entry that is renamed in the same cycle returns the old mapping and the old ready flag.
- R6: A writeback clears the pending flag of `wb_arch` only when that entry currently maps to `wb_phys`. With any other `wb_phys`, the flag stays set.
- R7: If a rename and a writeback hit the same entry in one cycle, the rename wins: the entry takes the new mapping and stays pending.
- R8: A commit writes `cm_phys` into entry `cm_arch` of the retired table and leaves the speculative table unchanged.
- R9: A rollback replaces every speculative entry with the retired mapping in one cycle and clears all pending flags. A commit given in the same cycle is included in the restored mapping.
- R10: `ren_ready` is 0 in a rollback cycle and 1 otherwise. A rename presented during rollback is not applied.
- R11: With `ren_valid` low, no speculative entry changes, whatever `ren_arch` and `ren_phys` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_arch | input | AW | Destination architectural register |
| ren_phys | input | PW | Newly allocated physical register |
| ren_old_phys | output | PW | Mapping being replaced |
| wb_valid | input | 1 | A producer completed |
| wb_arch | input | AW | Architectural register of the completed write |
| wb_phys | input | PW | Physical register that was written |
| cm_valid | input | 1 | An instruction retires with a destination |
| cm_arch | input | AW | Retiring destination architectural register |
| cm_phys | input | PW | Retiring physical register |
| rollback | input | 1 | Restore the speculative table from the retired table |
| src_arch | input | NS x AW | Source lookup indices, one per port |
| src_phys | output | NS x PW | Mapped physical registers |
| src_ready | output | NS | Source value already written |

## Verification
The hardest situation to reach is a rollback whose restored image differs from the reset identity map. In that situation, retired mappings, a commit issued in the rollback cycle itself, and a refused rename all have to be told apart at the lookup ports. The vector table first builds pending renames and a stale writeback. It then retires one mapping and raises rollback together with a second commit and a rename request. Later vectors look up each affected register, to show which mapping survived and that every entry is ready again.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  localparam int ARCH_REGS_DEF = 8;
  localparam int PHYS_REGS_DEF = 16;
  localparam int SRC_PORTS_DEF = 2;
endpackage

// File: rtl/rmap_commit_table.sv
module rmap_commit_table #(
  parameter int NA = rmap_pkg::ARCH_REGS_DEF,
  parameter int NP = rmap_pkg::PHYS_REGS_DEF,
  localparam int AW = $clog2(NA),
  localparam int PW = $clog2(NP)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cm_valid,
  input  logic [AW-1:0]          cm_arch,
  input  logic [PW-1:0]          cm_phys,
  output logic [NA-1:0][PW-1:0]  cmap_next
);
  logic [NA-1:0][PW-1:0] cmap_q;

  // next-state image also feeds the rollback path, so a same-cycle commit is kept
  always_comb begin
    cmap_next = cmap_q;
    if (cm_valid) cmap_next[cm_arch] = cm_phys;
  end

  for (genvar i = 0; i < NA; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) cmap_q[i] <= PW'(i);
      else        cmap_q[i] <= cmap_next[i];
    end
  end

  // R8: retired entry takes the committed pointer
  a_r8_commit_writes: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |=> cmap_q[$past(cm_arch)] == $past(cm_phys));
endmodule

// File: rtl/rmap_spec_table.sv
module rmap_spec_table #(
  parameter int NA = rmap_pkg::ARCH_REGS_DEF,
  parameter int NP = rmap_pkg::PHYS_REGS_DEF,
  localparam int AW = $clog2(NA),
  localparam int PW = $clog2(NP)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ren_fire,
  input  logic [AW-1:0]          ren_arch,
  input  logic [PW-1:0]          ren_phys,
  input  logic                   wb_valid,
  input  logic [AW-1:0]          wb_arch,
  input  logic [PW-1:0]          wb_phys,
  input  logic                   restore,
  input  logic [NA-1:0][PW-1:0]  restore_map,
  output logic [NA-1:0][PW-1:0]  map_o,
  output logic [NA-1:0]          pend_o,
  output logic [PW-1:0]          old_phys
);
  logic [NA-1:0][PW-1:0] map_q;
  logic [NA-1:0]         pend_q;

  assign map_o    = map_q;
  assign pend_o   = pend_q;
  assign old_phys = map_q[ren_arch];

  for (genvar i = 0; i < NA; i++) begin : g_ent
    logic ren_hit, wb_hit;
    assign ren_hit = ren_fire && (ren_arch == AW'(i));
    assign wb_hit  = wb_valid && (wb_arch == AW'(i)) && (map_q[i] == wb_phys);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        map_q[i]  <= PW'(i);
        pend_q[i] <= 1'b0;
      end else if (restore) begin
        map_q[i]  <= restore_map[i];
        pend_q[i] <= 1'b0;
      end else if (ren_hit) begin
        map_q[i]  <= ren_phys;
        pend_q[i] <= 1'b1;
      end else if (wb_hit) begin
        pend_q[i] <= 1'b0;
      end
    end
  end

  // R3: accepted rename installs mapping and marks it pending
  a_r3_install: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_fire && !restore) |=>
      (map_q[$past(ren_arch)] == $past(ren_phys)) && pend_q[$past(ren_arch)]);

  // R6: a writeback for a physical register no longer mapped leaves pending alone
  a_r6_stale_wb_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !restore && !(ren_fire && ren_arch == wb_arch) &&
     map_q[wb_arch] != wb_phys) |=>
      pend_q[$past(wb_arch)] == $past(pend_q[wb_arch]));

  // R9: rollback clears every pending flag and restores the retired image
  a_r9_rollback_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> pend_q == '0);
  a_r9_rollback_copies: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> map_q == $past(restore_map));
endmodule

// File: rtl/rmap_src_port.sv
module rmap_src_port #(
  parameter int NA = rmap_pkg::ARCH_REGS_DEF,
  parameter int NP = rmap_pkg::PHYS_REGS_DEF,
  localparam int AW = $clog2(NA),
  localparam int PW = $clog2(NP)
) (
  input  logic [NA-1:0][PW-1:0] map_i,
  input  logic [NA-1:0]         pend_i,
  input  logic [AW-1:0]         arch,
  output logic [PW-1:0]         phys,
  output logic                  ready
);
  assign phys  = map_i[arch];
  assign ready = ~pend_i[arch];
endmodule

// File: rtl/reg_map_unit.sv
module reg_map_unit #(
  parameter int NA = rmap_pkg::ARCH_REGS_DEF,
  parameter int NP = rmap_pkg::PHYS_REGS_DEF,
  parameter int NS = rmap_pkg::SRC_PORTS_DEF,
  localparam int AW = $clog2(NA),
  localparam int PW = $clog2(NP)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ren_valid,
  output logic                  ren_ready,
  input  logic [AW-1:0]         ren_arch,
  input  logic [PW-1:0]         ren_phys,
  output logic [PW-1:0]         ren_old_phys,
  input  logic                  wb_valid,
  input  logic [AW-1:0]         wb_arch,
  input  logic [PW-1:0]         wb_phys,
  input  logic                  cm_valid,
  input  logic [AW-1:0]         cm_arch,
  input  logic [PW-1:0]         cm_phys,
  input  logic                  rollback,
  input  logic [NS-1:0][AW-1:0] src_arch,
  output logic [NS-1:0][PW-1:0] src_phys,
  output logic [NS-1:0]         src_ready
);
  logic                  ren_fire;
  logic [NA-1:0][PW-1:0] cmap_next;
  logic [NA-1:0][PW-1:0] smap;
  logic [NA-1:0]         spend;

  assign ren_ready = ~rollback;
  assign ren_fire  = ren_valid & ren_ready;

  rmap_commit_table #(.NA(NA), .NP(NP)) i_commit (
    .clk(clk), .rst_n(rst_n),
    .cm_valid(cm_valid), .cm_arch(cm_arch), .cm_phys(cm_phys),
    .cmap_next(cmap_next)
  );

  rmap_spec_table #(.NA(NA), .NP(NP)) i_spec (
    .clk(clk), .rst_n(rst_n),
    .ren_fire(ren_fire), .ren_arch(ren_arch), .ren_phys(ren_phys),
    .wb_valid(wb_valid), .wb_arch(wb_arch), .wb_phys(wb_phys),
    .restore(rollback), .restore_map(cmap_next),
    .map_o(smap), .pend_o(spend), .old_phys(ren_old_phys)
  );

  for (genvar s = 0; s < NS; s++) begin : g_src
    rmap_src_port #(.NA(NA), .NP(NP)) i_port (
      .map_i(smap), .pend_i(spend), .arch(src_arch[s]),
      .phys(src_phys[s]), .ready(src_ready[s])
    );
  end

  // R10: nothing is written into the speculative table on a refused request
  a_r10_refused_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rollback && !$past(rollback)) |=> spend == '0);
endmodule

// File: tb/test_reg_map_unit.sv
module test_reg_map_unit;
  localparam int NA = 8, NP = 16, NS = 2;
  localparam int AW = $clog2(NA), PW = $clog2(NP);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ren_valid = 0, ren_ready, wb_valid = 0, cm_valid = 0, rollback = 0;
  logic [AW-1:0] ren_arch = 0, wb_arch = 0, cm_arch = 0;
  logic [PW-1:0] ren_phys = 0, ren_old_phys, wb_phys = 0, cm_phys = 0;
  logic [NS-1:0][AW-1:0] src_arch = '0;
  logic [NS-1:0][PW-1:0] src_phys;
  logic [NS-1:0] src_ready;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  reg_map_unit #(.NA(NA), .NP(NP), .NS(NS)) i_reg_map_unit (.*);

  typedef struct packed {
    logic rv; logic [2:0] ra; logic [3:0] rp;
    logic wv; logic [2:0] wa; logic [3:0] wp;
    logic cv; logic [2:0] ca; logic [3:0] cp;
    logic fl; logic [2:0] sa;
    logic [3:0] e_sp; logic e_sr; logic [3:0] e_old;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    // rv ra rp  wv wa wp  cv ca cp  fl sa  sp sr old req
    '{1, 1, 8,  0, 0, 0,  0, 0, 0,  0, 1,  1, 1, 1,  4},  // R4 old mapping of r1
    '{0, 0, 0,  0, 0, 0,  0, 0, 0,  0, 1,  8, 0, 0,  3},  // R3 r1 -> p8 pending
    '{0, 0, 0,  1, 1, 5,  0, 0, 0,  0, 1,  8, 0, 0,  6},  // R6 stale writeback p5
    '{1, 2, 9,  0, 0, 0,  0, 0, 0,  0, 1,  8, 0, 2,  6},  // R6 r1 still pending
    '{0, 0, 0,  1, 1, 8,  0, 0, 0,  0, 2,  9, 0, 0,  2},  // R2 r2 pending lookup
    '{1, 1, 10, 1, 1, 8,  0, 0, 0,  0, 1,  8, 1, 8,  7},  // R7 rename+wb same entry
    '{0, 0, 0,  0, 0, 0,  1, 1, 8,  0, 1,  10, 0, 0, 7},  // R7 rename won
    '{1, 3, 11, 0, 0, 0,  1, 2, 9,  1, 1,  10, 0, 3, 8},  // R8 commit left spec alone
    '{0, 0, 0,  0, 0, 0,  0, 0, 0,  0, 3,  3, 1, 0,  10}, // R10 refused rename
    '{0, 0, 0,  0, 0, 0,  0, 0, 0,  0, 2,  9, 1, 0,  9},  // R9 same-cycle commit kept
    '{0, 0, 0,  0, 0, 0,  0, 0, 0,  0, 1,  8, 1, 0,  9}   // R9 restored and ready
  };

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  task automatic idle();
    ren_valid = 0; wb_valid = 0; cm_valid = 0; rollback = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: identity map and nothing pending after reset, both ports
    for (int a = 0; a < NA; a++) begin
      src_arch[0] = AW'(a); src_arch[1] = AW'(NA - 1 - a);
      #1;
      check("R1", "port0 phys", src_phys[0], a);
      check("R1", "port1 phys", src_phys[1], NA - 1 - a);
      check("R1", "port0 ready", src_ready[0], 1);
    end
    for (int v = 0; v < NV; v++) begin
      string tag;
      @(negedge clk);
      ren_valid = VEC[v].rv; ren_arch = VEC[v].ra; ren_phys = VEC[v].rp;
      wb_valid = VEC[v].wv; wb_arch = VEC[v].wa; wb_phys = VEC[v].wp;
      cm_valid = VEC[v].cv; cm_arch = VEC[v].ca; cm_phys = VEC[v].cp;
      rollback = VEC[v].fl; src_arch[0] = VEC[v].sa;
      #2;
      tag = $sformatf("R%0d vec%0d", VEC[v].req, v);
      check(tag, "src_phys", src_phys[0], VEC[v].e_sp);
      check(tag, "src_ready", src_ready[0], VEC[v].e_sr);
      check(tag, "ren_old_phys", ren_old_phys, VEC[v].e_old);
      check(tag, "ren_ready", ren_ready, !VEC[v].fl);
    end
    // R5: same-cycle lookup on port 1 sees the old mapping of r4
    @(negedge clk); idle();
    ren_valid = 1; ren_arch = 4; ren_phys = 12; src_arch[1] = 4;
    #2;
    check("R5", "port1 phys", src_phys[1], 4);
    check("R5", "port1 ready", src_ready[1], 1);
    @(negedge clk); idle(); #2;
    check("R3", "port1 phys after", src_phys[1], 12);
    check("R3", "port1 ready after", src_ready[1], 0);
    // R11: request without valid changes nothing
    ren_arch = 5; ren_phys = 13; src_arch[1] = 5;
    @(negedge clk); #2;
    check("R11", "r5 phys", src_phys[1], 5);
    check("R11", "r5 ready", src_ready[1], 1);
    // R6: matching writeback clears r4
    wb_valid = 1; wb_arch = 4; wb_phys = 12; src_arch[0] = 4;
    @(negedge clk); idle(); #2;
    check("R6", "r4 ready after match", src_ready[0], 1);
    // R2: two ports differ in the same cycle
    src_arch[0] = 1; src_arch[1] = 4; #1;
    check("R2", "port0 r1", src_phys[0], 8);
    check("R2", "port1 r4", src_phys[1], 12);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule